// File: doc/BRIEF.md
# Locked Indirect Configuration Bank for a Spread-Spectrum Modem

This block is the configuration store that a processor uses to set up a spread-spectrum modem. The processor never addresses the registers directly. It first writes a bank index into an index port. It then reads or writes a data port, and that access reaches the register the index selects. The bank holds four registers: a mode/status register, a code-select register, an acquisition threshold and a fine-sync threshold. Their fields are exported continuously to the modem datapath.

The code-select register and both thresholds are guarded by a write lock. The lock is set at reset. To open it, the processor selects index 0xFF and writes 0xFF through the data port. Any other value written to 0xFF closes it again. While the lock is closed, writes to the guarded registers are dropped without any indication. Writing the mode/status register is never guarded, and every such write sends a one-cycle restart strobe to the frame search logic.

Top module: `mcfg_bank`

## Requirements
- R1: After reset: the lock is closed, the mode bit is 0 (receive), the code-select register is 0x00, the acquisition threshold is 0x40, the fine-sync threshold is 0x20 and the selected index is 0x00.
- R2: A write on the index port takes effect at the clock edge. From then on, `dat_rdata` combinationally shows the register at that index.
- R3: A data write of 0xFF while index 0xFF is selected opens the lock. Reading index 0xFF returns 0x01 while the lock is open and 0x00 while it is closed.
- R4: A data write of any value other than 0xFF while index 0xFF is selected closes the lock.
- R5: While the lock is closed, data writes to index 0x02, 0x04 or 0x05 leave both the stored value and the exported fields unchanged.
- R6: While the lock is open, data writes to index 0x02, 0x04 and 0x05 are stored at the clock edge and appear on the outputs from that edge on.
- R7: The code-select register is laid out as follows. Bit 7 = 1 selects the Kasami family and 0 selects Gold. Bit 6 = 1 selects the 15k chip rate and 0 selects 30k. Bits 4:0 hold the code address. Bit 5 always reads 0. In Kasami mode the exported code address is bits 2:0 with its upper two bits at zero. In Gold mode the exported code address is all five bits.
- R8: At index 0x00, bit 0 is the writable mode bit (1 = transmit), bit 1 reflects the frame-found input, bit 2 reflects the byte-ready input, and bits 7:3 read 0. Bit 0 can be written whatever the state of the lock.
- R9: Every data write to index 0x00 raises `restart` for exactly the one cycle after the write edge. Writes to any other index leave `restart` low.
- R10: Unused indices read 0x00, and data writes to them change no register and no output.
- R11: If an index write and a data write occur in the same cycle, the data write goes to the previously selected index, and the new index applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Bank index to select |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Data to write to the selected register |
| dat_rdata | output | 8 | Selected register contents (combinational) |
| frame_found | input | 1 | Datapath flag: frame header detected |
| byte_ready | input | 1 | Datapath flag: data byte available |
| tx_mode | output | 1 | 1 = transmit, 0 = receive |
| restart | output | 1 | One-cycle strobe that restarts the frame search |
| code_kasami | output | 1 | 1 = Kasami family, 0 = Gold |
| chip_slow | output | 1 | 1 = 15k chip rate, 0 = 30k |
| code_addr | output | 5 | Effective code address |
| acq_thresh | output | 8 | Acquisition threshold |
| fine_thresh | output | 8 | Fine-sync threshold |
| unlocked | output | 1 | Write lock is open |

## Verification
The one real collision in this block is an index write and a data write landing on the same clock edge. The bench forces this by asserting both strobes together. The old index points at the fine-sync threshold and the new one points at the acquisition threshold. The result counts as correct only if the fine-sync register takes the data and the acquisition register keeps its old value, with both read back afterwards. A second overlap is also covered: a data write to the mode register arriving while the datapath flags are active. The bench checks that the flags stay visible and are not overwritten by the written value.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] IDX_MODE  = 8'h00;
    localparam logic [DW-1:0] IDX_CODE  = 8'h02;
    localparam logic [DW-1:0] IDX_ACQ   = 8'h04;
    localparam logic [DW-1:0] IDX_FINE  = 8'h05;
    localparam logic [DW-1:0] IDX_LOCK  = 8'hFF;
    localparam logic [DW-1:0] KEY_OPEN  = 8'hFF;

    typedef struct packed {
        logic       kasami;
        logic       slow;
        logic       rsvd;
        logic [4:0] addr;
    } code_sel_t;

    typedef enum logic {LOCKED = 1'b0, OPEN = 1'b1} lock_e;

    function automatic logic is_guarded(input logic [DW-1:0] idx);
        return (idx == IDX_CODE) || (idx == IDX_ACQ) || (idx == IDX_FINE);
    endfunction

    function automatic logic [4:0] eff_code_addr(input code_sel_t c);
        return c.kasami ? {2'b00, c.addr[2:0]} : c.addr;
    endfunction

endpackage

// File: rtl/mcfg_index.sv
module mcfg_index
    import mcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] idx_o
);
    logic [DW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)       idx_q <= IDX_MODE;
        else if (wr_i) idx_q <= wdata_i;
    end

    assign idx_o = idx_q;

    AST_INDEX_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(wr_i) && !$past(rst) |-> idx_q == $past(wdata_i)); // R2
    AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_i) && !$past(rst) |-> $stable(idx_q)); // R11

endmodule

// File: rtl/mcfg_lock.sv
module mcfg_lock
    import mcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic          open_o
);
    lock_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LOCKED;
        end else if (wr_i && idx_i == IDX_LOCK) begin
            state_q <= (wdata_i == KEY_OPEN) ? OPEN : LOCKED;
        end
    end

    assign open_o = (state_q == OPEN);

    AST_LOCK_ONLY_VIA_KEY: assert property (@(posedge clk) disable iff (rst)
        !$stable(open_o) && !$past(rst) |-> $past(wr_i) && $past(idx_i) == IDX_LOCK); // R3
    AST_RELOCK_ON_OTHER: assert property (@(posedge clk) disable iff (rst)
        wr_i && idx_i == IDX_LOCK && wdata_i != KEY_OPEN |=> !open_o); // R4

endmodule

// File: rtl/mcfg_regs.sv
module mcfg_regs
    import mcfg_pkg::*;
#(
    parameter logic [DW-1:0] ACQ_RST  = 8'h40,
    parameter logic [DW-1:0] FINE_RST = 8'h20
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          open_i,
    input  logic          frame_i,
    input  logic          byte_i,
    output logic [DW-1:0] rdata_o,
    output logic          mode_o,
    output logic          restart_o,
    output code_sel_t     code_o,
    output logic [DW-1:0] acq_o,
    output logic [DW-1:0] fine_o
);
    logic          mode_q;
    logic          restart_q;
    code_sel_t     code_q;
    logic [DW-1:0] acq_q;
    logic [DW-1:0] fine_q;
    logic          wr_ok;

    assign wr_ok = wr_i && (open_i || !is_guarded(idx_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= 1'b0;
            restart_q <= 1'b0;
            code_q    <= '0;
            acq_q     <= ACQ_RST;
            fine_q    <= FINE_RST;
        end else begin
            restart_q <= wr_i && (idx_i == IDX_MODE);
            if (wr_ok) begin
                case (idx_i)
                    IDX_MODE: mode_q <= wdata_i[0];
                    IDX_CODE: begin
                        code_q      <= code_sel_t'(wdata_i);
                        code_q.rsvd <= 1'b0;
                    end
                    IDX_ACQ:  acq_q  <= wdata_i;
                    IDX_FINE: fine_q <= wdata_i;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (idx_i)
            IDX_MODE: rdata_o = {5'b0, byte_i, frame_i, mode_q};
            IDX_CODE: rdata_o = code_q;
            IDX_ACQ:  rdata_o = acq_q;
            IDX_FINE: rdata_o = fine_q;
            default:  rdata_o = '0;
        endcase
    end

    assign mode_o    = mode_q;
    assign restart_o = restart_q;
    assign code_o    = code_q;
    assign acq_o     = acq_q;
    assign fine_o    = fine_q;

    AST_GUARDED_HOLD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !$past(open_i) && !$past(rst) |-> $stable(code_q) && $stable(acq_q) && $stable(fine_q)); // R5
    AST_RESTART_FROM_MODE_WR: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> $past(wr_i) && $past(idx_i) == IDX_MODE); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        code_q.rsvd == 1'b0); // R7

endmodule

// File: rtl/mcfg_bank.sv
module mcfg_bank
    import mcfg_pkg::*;
#(
    parameter logic [7:0] ACQ_RST  = 8'h40,
    parameter logic [7:0] FINE_RST = 8'h20
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] idx_wdata,
    input  logic       dat_wr,
    input  logic [7:0] dat_wdata,
    output logic [7:0] dat_rdata,
    input  logic       frame_found,
    input  logic       byte_ready,
    output logic       tx_mode,
    output logic       restart,
    output logic       code_kasami,
    output logic       chip_slow,
    output logic [4:0] code_addr,
    output logic [7:0] acq_thresh,
    output logic [7:0] fine_thresh,
    output logic       unlocked
);
    logic [DW-1:0] idx;
    logic [DW-1:0] reg_rdata;
    logic          open_w;
    code_sel_t     code_w;

    mcfg_index i_index (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (idx_wr),
        .wdata_i (idx_wdata),
        .idx_o   (idx)
    );

    mcfg_lock i_lock (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (dat_wr),
        .idx_i   (idx),
        .wdata_i (dat_wdata),
        .open_o  (open_w)
    );

    mcfg_regs #(.ACQ_RST(ACQ_RST), .FINE_RST(FINE_RST)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (dat_wr),
        .idx_i     (idx),
        .wdata_i   (dat_wdata),
        .open_i    (open_w),
        .frame_i   (frame_found),
        .byte_i    (byte_ready),
        .rdata_o   (reg_rdata),
        .mode_o    (tx_mode),
        .restart_o (restart),
        .code_o    (code_w),
        .acq_o     (acq_thresh),
        .fine_o    (fine_thresh)
    );

    assign dat_rdata   = (idx == IDX_LOCK) ? {7'b0, open_w} : reg_rdata;
    assign code_kasami = code_w.kasami;
    assign chip_slow   = code_w.slow;
    assign code_addr   = eff_code_addr(code_w);
    assign unlocked    = open_w;

    AST_KASAMI_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        code_kasami |-> code_addr[4:3] == 2'b00); // R7
    AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        idx inside {8'h01, 8'h03, [8'h06:8'hFE]} |-> dat_rdata == 8'h00); // R10

endmodule

// File: tb/test_mcfg_bank.sv
module test_mcfg_bank;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic       idx_wr = 0;
    logic [7:0] idx_wdata = 0;
    logic       dat_wr = 0;
    logic [7:0] dat_wdata = 0;
    logic [7:0] dat_rdata;
    logic       frame_found = 0;
    logic       byte_ready = 0;
    logic       tx_mode, restart, code_kasami, chip_slow, unlocked;
    logic [4:0] code_addr;
    logic [7:0] acq_thresh, fine_thresh;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcfg_bank i_mcfg_bank (
        .clk(clk), .rst(rst),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .frame_found(frame_found), .byte_ready(byte_ready),
        .tx_mode(tx_mode), .restart(restart),
        .code_kasami(code_kasami), .chip_slow(chip_slow), .code_addr(code_addr),
        .acq_thresh(acq_thresh), .fine_thresh(fine_thresh), .unlocked(unlocked)
    );

    // op: 0 = index write, 1 = data write, 2 = read check
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] val;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'h02, 8'h00, 4'd5},  '{2'd1, 8'h8C, 8'h00, 4'd5},  '{2'd2, 8'h00, 8'h00, 4'd5},
        '{2'd0, 8'hFF, 8'h00, 4'd3},  '{2'd2, 8'h00, 8'h00, 4'd3},  '{2'd1, 8'hFF, 8'h00, 4'd3},
        '{2'd2, 8'h00, 8'h01, 4'd3},  '{2'd0, 8'h02, 8'h00, 4'd6},  '{2'd1, 8'hBD, 8'h00, 4'd6},
        '{2'd2, 8'h00, 8'h9D, 4'd7},  '{2'd0, 8'h04, 8'h00, 4'd6},  '{2'd1, 8'h33, 8'h00, 4'd6},
        '{2'd2, 8'h00, 8'h33, 4'd6},  '{2'd0, 8'h05, 8'h00, 4'd6},  '{2'd1, 8'h7A, 8'h00, 4'd6},
        '{2'd2, 8'h00, 8'h7A, 4'd6},  '{2'd0, 8'hFF, 8'h00, 4'd4},  '{2'd1, 8'h12, 8'h00, 4'd4},
        '{2'd2, 8'h00, 8'h00, 4'd4},  '{2'd0, 8'h04, 8'h00, 4'd5},  '{2'd1, 8'h55, 8'h00, 4'd5},
        '{2'd2, 8'h00, 8'h33, 4'd5},  '{2'd0, 8'h07, 8'h00, 4'd10}, '{2'd1, 8'hAA, 8'h00, 4'd10},
        '{2'd2, 8'h00, 8'h00, 4'd10}, '{2'd0, 8'h00, 8'h00, 4'd8},  '{2'd1, 8'hFF, 8'h00, 4'd8},
        '{2'd2, 8'h00, 8'h01, 4'd8},  '{2'd1, 8'h00, 8'h00, 4'd8},  '{2'd2, 8'h00, 8'h00, 4'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sel(input logic [7:0] a);
        idx_wr = 1; idx_wdata = a;
        @(posedge clk); @(negedge clk);
        idx_wr = 0;
    endtask

    task automatic put(input logic [7:0] d);
        dat_wr = 1; dat_wdata = d;
        @(posedge clk); @(negedge clk);
        dat_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        check("R1 rdata", dat_rdata, 8'h00);
        check("R1 acq", acq_thresh, 8'h40);
        check("R1 fine", fine_thresh, 8'h20);
        check("R1 lock", unlocked, 1'b0);
        check("R1 mode", tx_mode, 1'b0);
        check("R1 code", {code_kasami, chip_slow, code_addr}, 7'h00);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: sel(VECS[i].val);
                2'd1: put(VECS[i].val);
                default: check($sformatf("R%0d vec%0d", VECS[i].req, i), dat_rdata, VECS[i].exp);
            endcase
        end

        // R7 Kasami code address truncation (stored 0x9D)
        check("R7 kasami", code_kasami, 1'b1);
        check("R7 slow", chip_slow, 1'b0);
        check("R7 kasami addr", code_addr, 5'd5);
        // R5 locked: outputs held from earlier writes
        check("R5 acq out", acq_thresh, 8'h33);
        check("R10 fine untouched", fine_thresh, 8'h7A);

        // R6 / R7 Gold with full address, slow rate
        sel(8'hFF); put(8'hFF);
        sel(8'h02); put(8'h7F);
        check("R7 readback", dat_rdata, 8'h5F);
        check("R7 gold", code_kasami, 1'b0);
        check("R7 slow", chip_slow, 1'b1);
        check("R7 gold addr", code_addr, 5'd31);

        // R9 restart strobe
        check("R9 idle", restart, 1'b0);
        sel(8'h00);
        dat_wr = 1; dat_wdata = 8'h01;
        @(posedge clk); @(negedge clk);
        dat_wr = 0;
        check("R9 pulse", restart, 1'b1);
        check("R8 tx mode", tx_mode, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R9 single", restart, 1'b0);
        sel(8'h04); put(8'h21);
        check("R9 other idx", restart, 1'b0);

        // R8 flags with a concurrent mode write
        sel(8'h00);
        frame_found = 1; byte_ready = 1;
        put(8'hF8);
        check("R8 flags", dat_rdata, 8'h06);
        frame_found = 0;
        #1 check("R8 byte only", dat_rdata, 8'h04);
        byte_ready = 0;

        // R11 same-cycle index and data write
        sel(8'h05);
        idx_wr = 1; idx_wdata = 8'h04; dat_wr = 1; dat_wdata = 8'h66;
        @(posedge clk); @(negedge clk);
        idx_wr = 0; dat_wr = 0;
        check("R11 new idx old value", dat_rdata, 8'h21);
        check("R11 fine got data", fine_thresh, 8'h66);

        // R2 selection is combinational on read
        sel(8'h05);
        check("R2 read fine", dat_rdata, 8'h66);

        // R1 reset mid-run restores defaults
        rst = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 0;
        check("R1 acq again", acq_thresh, 8'h40);
        check("R1 relocked", unlocked, 1'b0);
        check("R1 idx zero", dat_rdata, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule